// File: doc/BRIEF.md
# Receive lane reset sequencer

This block brings up the receive half of a serial transceiver lane whose elastic receive buffer is in use. It holds the physical-medium-attachment (PMA) reset for a fixed span, waits for the clock-data-recovery circuit to report lock and for the receive user clocks to be stable, then issues and releases the PCS reset. After a settling time it reports the lane ready.

While ready, the block watches for two kinds of fault. The first is a buffer error. The second is a burst of decode errors, meaning disparity errors or words that are not in the code table. On a fault it reissues only the PCS reset and counts the retry. Once the retry budget is spent, the next fault restarts the whole sequence from the PMA reset. A loss of lock at any point after lock was first reached also restarts from the PMA reset.

The sequencer runs on a free-running system clock, because the receive user clocks may be missing during reset. Every wait is given in cycles of the slower receive user clock and scaled to system clock cycles by `SYS_PER_UCLK`. All status inputs pass through two-flop synchronizers, so the sequencer sees them two system cycles late.

Top module: `rx_reset_seq`

## Requirements
- R1: While `rst_ni` is low, `pma_rst_o`=1, `pcs_rst_o`=1, `rx_ready_o`=0 and `retry_cnt_o`=0.
- R2: On entry to the PMA reset phase (including reset release), `pma_rst_o` stays high for exactly `PMA_HOLD_CYC` system cycles and then falls, while `pcs_rst_o` stays high.
- R3: After the PMA phase, the block waits with `pma_rst_o`=0 and `pcs_rst_o`=1 until both `cdr_lock_i` and `clks_stable_i`, seen through a 2-cycle synchronizer, are high.
- R4: The PCS reset is then held for `PCS_UCYC*SYS_PER_UCLK` system cycles and released. After at least `SETTLE_UCYC*SYS_PER_UCLK` further cycles, and once the user clocks are stable, the block becomes ready.
- R5: `rx_ready_o` is high only in the ready state, and always with both resets low.
- R6: A decode error is a sample with `disp_err_i` or `not_in_table_i` high, one sample per system cycle. It counts as a fault only when at least `ERR_THR` of the last `ERR_WIN` samples in the ready state are errored. Fewer errored samples are ignored.
- R7: A single-cycle `buf_err_i` pulse in the ready state is a fault.
- R8: A fault in the ready state with lock held, and with `retry_cnt_o` below `MAX_PCS_RETRY`, increments `retry_cnt_o` by 1 and reissues the PCS reset only; `pma_rst_o` stays low.
- R9: A fault while `retry_cnt_o` equals `MAX_PCS_RETRY` returns the block to the PMA reset phase. `retry_cnt_o` is cleared to 0 during that phase.
- R10: Loss of synchronized lock in the PCS reset, settling or ready state returns the block to the PMA reset phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clks_stable_i | input | 1 | Receive user clocks are stable (asynchronous) |
| cdr_lock_i | input | 1 | Clock-data-recovery lock (asynchronous) |
| buf_err_i | input | 1 | Receive elastic buffer error (asynchronous) |
| disp_err_i | input | 1 | Running-disparity error on the current word |
| not_in_table_i | input | 1 | Current word not in the code table |
| pma_rst_o | output | 1 | PMA reset to the transceiver |
| pcs_rst_o | output | 1 | PCS reset to the transceiver |
| rx_ready_o | output | 1 | Receive lane is up |
| retry_cnt_o | output | $clog2(MAX_PCS_RETRY+1) | PCS retries since the last PMA reset |

## Verification
The assertions assume the reset input is the only asynchronous event inside a run. They also assume retries can only be counted up one at a time from zero, which holds because the fault inputs reach the state machine only through the synchronizers. The stimulus changes every input on the falling clock edge, so each synchronizer sees a clean level. Lock drops and buffer errors are kept rare enough that the lane regularly reaches the ready state. Decode errors are dense enough that both isolated errors and true bursts occur.

// File: rtl/rx_reset_seq_pkg.sv
package rx_reset_seq_pkg;
  typedef enum logic [2:0] {
    ST_PMA    = 3'd0,
    ST_LOCK   = 3'd1,
    ST_PCS    = 3'd2,
    ST_SETTLE = 3'd3,
    ST_READY  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/rx_reset_sync.sv
module rx_reset_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/rx_reset_err_mon.sv
module rx_reset_err_mon #(
  parameter int ERR_WIN = 16,
  parameter int ERR_THR = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic word_err_i,
  input  logic buf_err_i,
  output logic fault_o
);
  logic [ERR_WIN-1:0] win_q;

  // sliding window of errored samples, emptied outside the ready state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     win_q <= '0;
    else if (clr_i)  win_q <= '0;
    else             win_q <= {win_q[ERR_WIN-2:0], word_err_i};
  end

  assign fault_o = buf_err_i || ($countones(win_q) >= ERR_THR);
endmodule

// File: rtl/rx_reset_seq.sv
module rx_reset_seq
  import rx_reset_seq_pkg::*;
#(
  parameter int SYS_PER_UCLK  = 2,
  parameter int PMA_HOLD_CYC  = 16384,
  parameter int PCS_UCYC      = 4,
  parameter int SETTLE_UCYC   = 16,
  parameter int MAX_PCS_RETRY = 3,
  parameter int ERR_WIN       = 16,
  parameter int ERR_THR       = 4,
  localparam int RW = $clog2(MAX_PCS_RETRY + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clks_stable_i,
  input  logic          cdr_lock_i,
  input  logic          buf_err_i,
  input  logic          disp_err_i,
  input  logic          not_in_table_i,
  output logic          pma_rst_o,
  output logic          pcs_rst_o,
  output logic          rx_ready_o,
  output logic [RW-1:0] retry_cnt_o
);
  localparam int PCS_CYC    = PCS_UCYC * SYS_PER_UCLK;
  localparam int SETTLE_CYC = SETTLE_UCYC * SYS_PER_UCLK;
  localparam int MAX_A      = (PMA_HOLD_CYC > PCS_CYC) ? PMA_HOLD_CYC : PCS_CYC;
  localparam int MAX_LIM    = (MAX_A > SETTLE_CYC) ? MAX_A : SETTLE_CYC;
  localparam int CW         = $clog2(MAX_LIM + 1);
  localparam logic [CW-1:0] PMA_LAST    = CW'(PMA_HOLD_CYC - 1);
  localparam logic [CW-1:0] PCS_LAST    = CW'(PCS_CYC - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);
  localparam logic [RW-1:0] RETRY_MAX   = RW'(MAX_PCS_RETRY);

  logic [4:0] async_in, sync_out;
  logic lock_s, stable_s, buf_s, disp_s, nit_s;
  logic fault;

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic [RW-1:0] retry_q;

  assign async_in = {cdr_lock_i, clks_stable_i, buf_err_i, disp_err_i, not_in_table_i};
  assign {lock_s, stable_s, buf_s, disp_s, nit_s} = sync_out;

  rx_reset_sync #(.W(5)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (async_in),
    .q_o    (sync_out)
  );

  rx_reset_err_mon #(.ERR_WIN(ERR_WIN), .ERR_THR(ERR_THR)) u_err (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (state_q != ST_READY),
    .word_err_i (disp_s | nit_s),
    .buf_err_i  (buf_s),
    .fault_o    (fault)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PMA:    if (cnt_q >= PMA_LAST) state_d = ST_LOCK;
      ST_LOCK:   if (lock_s && stable_s) state_d = ST_PCS;
      ST_PCS:    if (!lock_s) state_d = ST_PMA;
                 else if (cnt_q >= PCS_LAST) state_d = ST_SETTLE;
      ST_SETTLE: if (!lock_s) state_d = ST_PMA;
                 else if (cnt_q >= SETTLE_LAST && stable_s) state_d = ST_READY;
      ST_READY:  if (!lock_s) state_d = ST_PMA;
                 else if (fault) state_d = (retry_q == RETRY_MAX) ? ST_PMA : ST_PCS;
      default:   state_d = ST_PMA;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PMA;
      cnt_q   <= '0;
      retry_q <= '0;
    end else begin
      state_q <= state_d;
      // per-state timer, restarted on every transition, saturating
      if (state_d != state_q) cnt_q <= '0;
      else if (cnt_q != '1)   cnt_q <= cnt_q + 1'b1;
      if (state_q == ST_PMA)
        retry_q <= '0;
      else if (state_q == ST_READY && lock_s && fault && retry_q != RETRY_MAX)
        retry_q <= retry_q + 1'b1;
    end
  end

  assign pma_rst_o   = (state_q == ST_PMA);
  assign pcs_rst_o   = (state_q == ST_PMA) || (state_q == ST_LOCK) || (state_q == ST_PCS);
  assign rx_ready_o  = (state_q == ST_READY);
  assign retry_cnt_o = retry_q;
endmodule

// File: rtl/rx_reset_seq_chk.sv
module rx_reset_seq_chk #(
  parameter int MAX_PCS_RETRY = 3,
  parameter int PMA_HOLD_CYC  = 16384,
  localparam int RW = $clog2(MAX_PCS_RETRY + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pma_rst_o,
  input logic          pcs_rst_o,
  input logic          rx_ready_o,
  input logic [RW-1:0] retry_cnt_o
);
  int unsigned hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_cnt <= 0;
    else if (!pma_rst_o) hi_cnt <= 0;
    else if (hi_cnt != 32'hFFFF_FFFF) hi_cnt <= hi_cnt + 1;
  end

  assert_pma_span_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pma_rst_o && $past(pma_rst_o)) |-> hi_cnt == PMA_HOLD_CYC);

  assert_pma_implies_pcs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pma_rst_o |-> pcs_rst_o);

  assert_ready_clean_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |-> (!pma_rst_o && !pcs_rst_o));

  assert_retry_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(retry_cnt_o) |-> (retry_cnt_o == '0 || retry_cnt_o == RW'($past(retry_cnt_o) + 1'b1)));

  assert_retry_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_cnt_o <= RW'(MAX_PCS_RETRY));

  assert_pma_clears_retry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pma_rst_o |=> retry_cnt_o == '0);
endmodule

bind rx_reset_seq rx_reset_seq_chk #(
  .MAX_PCS_RETRY (MAX_PCS_RETRY),
  .PMA_HOLD_CYC  (PMA_HOLD_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pma_rst_o   (pma_rst_o),
  .pcs_rst_o   (pcs_rst_o),
  .rx_ready_o  (rx_ready_o),
  .retry_cnt_o (retry_cnt_o)
);

// File: tb/rx_reset_seq_bench.sv
module rx_reset_seq_bench;
  localparam int SYS  = 2;
  localparam int PMA  = 20;
  localparam int PCSU = 3;
  localparam int SETU = 4;
  localparam int MAXR = 3;
  localparam int WIN  = 16;
  localparam int THR  = 4;
  localparam int RW   = $clog2(MAXR + 1);
  localparam int PCS_C = PCSU * SYS;
  localparam int SET_C = SETU * SYS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stable = 1'b0, lock = 1'b0, buf_e = 1'b0, disp = 1'b0, nit = 1'b0;
  logic pma, pcs, rdy;
  logic [RW-1:0] retry;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rx_reset_seq #(
    .SYS_PER_UCLK(SYS), .PMA_HOLD_CYC(PMA), .PCS_UCYC(PCSU), .SETTLE_UCYC(SETU),
    .MAX_PCS_RETRY(MAXR), .ERR_WIN(WIN), .ERR_THR(THR)
  ) u_rx_reset_seq (
    .clk_i(clk), .rst_ni(rst_n), .clks_stable_i(stable), .cdr_lock_i(lock),
    .buf_err_i(buf_e), .disp_err_i(disp), .not_in_table_i(nit),
    .pma_rst_o(pma), .pcs_rst_o(pcs), .rx_ready_o(rdy), .retry_cnt_o(retry)
  );

  // expected behaviour, built from the requirements
  // states: 0 PMA, 1 wait lock, 2 PCS reset, 3 settle, 4 ready
  int m_st, m_cnt, m_retry;
  logic [4:0] m_s1, m_s2;
  logic [WIN-1:0] m_win;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_retry = 0; m_s1 = '0; m_s2 = '0; m_win = '0;
    end else begin
      logic lk, st, fault;
      int nx;
      lk = m_s2[4]; st = m_s2[3];
      fault = m_s2[2] || ($countones(m_win) >= THR);
      nx = m_st;
      case (m_st)
        0: if (m_cnt >= PMA - 1) nx = 1;
        1: if (lk && st) nx = 2;
        2: if (!lk) nx = 0; else if (m_cnt >= PCS_C - 1) nx = 3;
        3: if (!lk) nx = 0; else if (m_cnt >= SET_C - 1 && st) nx = 4;
        default: if (!lk) nx = 0; else if (fault) nx = (m_retry == MAXR) ? 0 : 2;
      endcase
      if (m_st == 0) m_retry = 0;
      else if (m_st == 4 && lk && fault && m_retry != MAXR) m_retry = m_retry + 1;
      if (m_st != 4) m_win = '0; else m_win = {m_win[WIN-2:0], m_s2[1] | m_s2[0]};
      m_cnt = (nx != m_st) ? 0 : m_cnt + 1;
      m_st = nx;
      m_s2 = m_s1;
      m_s1 = {lock, stable, buf_e, disp, nit};
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // advance one cycle and compare all outputs with the expected model
  task automatic cyc();
    @(negedge clk);
    chk("R2 pma_rst", int'(pma), int'(m_st == 0));
    chk("R4 pcs_rst", int'(pcs), int'(m_st <= 2));
    chk("R5 rx_ready", int'(rdy), int'(m_st == 4));
    chk("R8 retry_cnt", int'(retry), m_retry);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs while in reset
    chk("R1 pma", int'(pma), 1); chk("R1 pcs", int'(pcs), 1);
    chk("R1 ready", int'(rdy), 0); chk("R1 retry", int'(retry), 0);
    rst_n = 1'b1;
    // R2: PMA span exactly PMA cycles
    run(PMA - 1);
    chk("R2 pma still high", int'(pma), 1);
    run(1);
    chk("R2 pma released", int'(pma), 0);
    // R3: no progress without lock and stable clocks
    run(15);
    chk("R3 pcs held without lock", int'(pcs), 1);
    lock = 1'b1;
    run(10);
    chk("R3 pcs held without stable clocks", int'(pcs), 1);
    stable = 1'b1;
    run(3);
    chk("R3 pcs after sync", int'(pcs), 1);
    run(PCS_C);
    chk("R4 pcs released", int'(pcs), 0);
    run(SET_C + 2);
    chk("R4 ready", int'(rdy), 1);
    // R6: three errors in one window are ignored
    for (int k = 0; k < 3; k++) begin
      disp = (k != 1); nit = (k == 1); cyc();
      disp = 1'b0; nit = 1'b0; run(3);
    end
    run(20);
    chk("R6 isolated errors ignored retry", int'(retry), 0);
    chk("R6 isolated errors ignored ready", int'(rdy), 1);
    // R6/R8: burst of THR errors forces a PCS retry
    disp = 1'b1; run(THR); disp = 1'b0;
    run(6);
    chk("R8 retry after burst", int'(retry), 1);
    chk("R8 pma stays low", int'(pma), 0);
    run(40);
    chk("R8 ready again", int'(rdy), 1);
    // R7: buffer error pulses
    buf_e = 1'b1; cyc(); buf_e = 1'b0;
    run(8);
    chk("R7 retry after buf err", int'(retry), 2);
    run(40);
    buf_e = 1'b1; cyc(); buf_e = 1'b0;
    run(40);
    chk("R7 retry at max", int'(retry), MAXR);
    chk("R7 ready at max", int'(rdy), 1);
    // R9: escalation to PMA reset
    buf_e = 1'b1; cyc(); buf_e = 1'b0;
    run(8);
    chk("R9 escalated pma", int'(pma), 1);
    chk("R9 retry cleared", int'(retry), 0);
    run(60);
    chk("R9 ready after full restart", int'(rdy), 1);
    // R10: one-cycle lock loss
    lock = 1'b0; cyc(); lock = 1'b1;
    run(5);
    chk("R10 pma after lock loss", int'(pma), 1);
    run(80);
    // random phase with fixed seed
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      lock   = ($urandom % 250) != 0;
      stable = ($urandom % 300) != 0;
      disp   = ($urandom % 10) == 0;
      nit    = ($urandom % 14) == 0;
      buf_e  = ($urandom % 500) == 0;
      cyc();
    end
    // mid-run reset
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 pma in reset", int'(pma), 1);
    chk("R1 retry in reset", int'(retry), 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule